// File: doc/BRIEF.md
# Per-Pin Edge-Selectable Input Event Detector

This block watches a group of asynchronous input pins and turns their transitions into interrupt events. Each pin first passes through a two-stage synchronizer. The block then compares the synchronized level with the level from the previous cycle. A 2-bit mode field for each pin chooses which transitions count: rising, falling, both or neither. Rising and falling transitions are reported on two separate event vectors, so a downstream status collector can latch and clear them in separate groups. Software can OR the two groups to get one summary per pin.

The mode fields sit in a small bank of configuration words on a simple register port. Each word holds the fields for four pins. The block holds no status of its own. Each event is a pulse that lasts one clock. Latching, clearing, pin direction and output drive are handled by other blocks.

Top module: `pin_edge_detect`

## Requirements
- R1: Mode field layout. Pin n uses word n/4 (address 0 holds pins 0 to 3, address 1 holds pins 4 to 7), bits [2*(n%4)+1 : 2*(n%4)]. Bit 0 of a field enables rising detection and bit 1 enables falling detection.
- R2: When the synchronized level of a pin goes from 0 to 1 and its rising bit is set, `riseEvt[n]` pulses.
- R3: When the synchronized level of a pin goes from 1 to 0 and its falling bit is set, `fallEvt[n]` pulses.
- R4: With field value 11, a pin reports both directions, each on its own vector.
- R5: With field value 00, a pin never produces an event on either vector.
- R6: An input change driven before clock edge A shows on the event output after edge A+2, not earlier. The pulse lasts exactly one cycle.
- R7: The first level sampled after reset produces no event, even when it differs from the reset state of the synchronizer.
- R8: A write to a mode word takes effect at the next clock edge. Changing a mode while the pins are steady creates no event.
- R9: Reset clears all mode words to zero and drives both event vectors to zero.
- R10: `regRdData` returns the mode word selected by `regAddr`, as last written.
- R11: A pin never pulses on both event vectors in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Input pins, asynchronous to clk |
| regWrEn | input | 1 | Write strobe for the mode words |
| regAddr | input | 1 | Mode word index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed mode word |
| riseEvt | output | 8 | One-cycle rising-edge events, one bit per pin |
| fallEvt | output | 8 | One-cycle falling-edge events, one bit per pin |

## Verification
On every cycle the checker confirms four things:
- Each event bit traces back to a matching transition on the pin three and four edges earlier.
- No pin pulses twice in a row or on both vectors at once.
- No event appears on a pin whose mode was zero.
- A register write lands at the next edge.

Only the bench scenarios can show the exact latency of the first pulse, the suppression of the first sample after reset, and that mode changes alone stay silent. The same holds for the field-to-pin mapping across many mixed patterns, whose expected values are computed from the layout rule.

// File: rtl/ped_pkg.sv
package ped_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic wrStb;   // register write this cycle
    logic armed;   // synchronizer history holds real samples
  } ped_ctl_t;
endpackage

// File: rtl/ped_ctrl.sv
module ped_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  output ped_pkg::ped_ctl_t ctl
);
  // samples needed before comparison uses real data: sync stages plus history
  localparam int FILL   = SYNC_STAGES + 1;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [FILL_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (fillCnt != FILL_W'(FILL)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.wrStb = regWrEn;
    ctl.armed = (fillCnt == FILL_W'(FILL));
  end
endmodule

// File: rtl/ped_datapath.sv
module ped_datapath #(
  parameter int PIN_COUNT    = 8,
  parameter int PINS_PER_REG = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int REG_COUNT   = PIN_COUNT / PINS_PER_REG,
  localparam int DATA_W      = 2 * PINS_PER_REG,
  localparam int ADDR_W      = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ped_pkg::ped_ctl_t      ctl,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic [PIN_COUNT-1:0]   pinIn,
  output logic [DATA_W-1:0]      regRdData,
  output logic [2*PIN_COUNT-1:0] edgeCfg,
  output logic [PIN_COUNT-1:0]   riseEvt,
  output logic [PIN_COUNT-1:0]   fallEvt
);
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] prevLvl;
  logic [PIN_COUNT-1:0] riseMask;
  logic [PIN_COUNT-1:0] fallMask;
  logic [PIN_COUNT-1:0] curLvl;

  // mode words
  for (genvar r = 0; r < REG_COUNT; r++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        edgeCfg[r*DATA_W +: DATA_W] <= '0;
      end else if (ctl.wrStb && regAddr == ADDR_W'(r)) begin
        edgeCfg[r*DATA_W +: DATA_W] <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int r = 0; r < REG_COUNT; r++) begin
      if (regAddr == ADDR_W'(r)) regRdData = edgeCfg[r*DATA_W +: DATA_W];
    end
  end

  // per-pin field split
  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    assign riseMask[n] = edgeCfg[2*n];
    assign fallMask[n] = edgeCfg[2*n+1];
  end

  // synchronizer chain and history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevLvl <= syncQ[SYNC_STAGES-1];
    end
  end

  assign curLvl = syncQ[SYNC_STAGES-1];

  // registered single-cycle events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseEvt <= '0;
      fallEvt <= '0;
    end else if (ctl.armed) begin
      riseEvt <= curLvl & ~prevLvl & riseMask;
      fallEvt <= ~curLvl & prevLvl & fallMask;
    end else begin
      riseEvt <= '0;
      fallEvt <= '0;
    end
  end
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int PIN_COUNT    = 8,
  parameter int PINS_PER_REG = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int REG_COUNT   = PIN_COUNT / PINS_PER_REG,
  localparam int DATA_W      = 2 * PINS_PER_REG,
  localparam int ADDR_W      = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic [PIN_COUNT-1:0] riseEvt,
  output logic [PIN_COUNT-1:0] fallEvt
);
  ped_pkg::ped_ctl_t      ctl;
  logic [2*PIN_COUNT-1:0] edgeCfg;

  ped_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .ctl     (ctl)
  );

  ped_datapath #(
    .PIN_COUNT    (PIN_COUNT),
    .PINS_PER_REG (PINS_PER_REG),
    .SYNC_STAGES  (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .pinIn     (pinIn),
    .regRdData (regRdData),
    .edgeCfg   (edgeCfg),
    .riseEvt   (riseEvt),
    .fallEvt   (fallEvt)
  );
endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
  parameter int PIN_COUNT    = 8,
  parameter int PINS_PER_REG = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int DATA_W      = 2 * PINS_PER_REG,
  localparam int REG_COUNT   = PIN_COUNT / PINS_PER_REG,
  localparam int ADDR_W      = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [PIN_COUNT-1:0]   pinIn,
  input logic                   regWrEn,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [DATA_W-1:0]      regWrData,
  input logic [2*PIN_COUNT-1:0] edgeCfg,
  input logic [PIN_COUNT-1:0]   riseEvt,
  input logic [PIN_COUNT-1:0]   fallEvt
);
  localparam int NEWD = SYNC_STAGES + 1;
  localparam int OLDD = SYNC_STAGES + 2;

  logic [PIN_COUNT-1:0] riseEn;
  logic [PIN_COUNT-1:0] fallEn;
  always_comb begin
    for (int n = 0; n < PIN_COUNT; n++) begin
      riseEn[n] = edgeCfg[2*n];
      fallEn[n] = edgeCfg[2*n+1];
    end
  end

  assert_rise_origin_R2: assert property (@(posedge clk) disable iff (!rstN)
    (riseEvt != '0) |-> ((riseEvt & ~($past(pinIn, NEWD) & ~$past(pinIn, OLDD))) == '0));

  assert_fall_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fallEvt != '0) |-> ((fallEvt & ~(~$past(pinIn, NEWD) & $past(pinIn, OLDD))) == '0));

  assert_mode_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((riseEvt & ~$past(riseEn)) == '0) && ((fallEvt & ~$past(fallEn)) == '0));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (riseEvt != '0 || fallEvt != '0) |=>
      ((riseEvt & $past(riseEvt)) == '0) && ((fallEvt & $past(fallEvt)) == '0));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0) |=> (edgeCfg[DATA_W-1:0] == $past(regWrData)));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    (riseEvt & fallEvt) == '0);
endmodule

bind pin_edge_detect ped_checker #(
  .PIN_COUNT    (PIN_COUNT),
  .PINS_PER_REG (PINS_PER_REG),
  .SYNC_STAGES  (SYNC_STAGES)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .edgeCfg   (edgeCfg),
  .riseEvt   (riseEvt),
  .fallEvt   (fallEvt)
);

// File: tb/test_pin_edge_detect.sv
`timescale 1ns/1ps
module test_pin_edge_detect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = 8'h00;
  logic       regWrEn = 1'b0;
  logic [0:0] regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData, riseEvt, fallEvt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pin_edge_detect i_pin_edge_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  // {mode words hi:lo, start level, end level}
  localparam logic [31:0] VEC [8] = '{
    {16'h5555, 8'h00, 8'hFF},   // R2 all rising
    {16'hAAAA, 8'hFF, 8'h00},   // R3 all falling
    {16'hFFFF, 8'h0F, 8'hF0},   // R4 both
    {16'h0000, 8'h00, 8'hFF},   // R5 none
    {16'h1B1B, 8'h55, 8'hAA},   // R1 mixed fields
    {16'hFF00, 8'h00, 8'hFF},   // R1 upper word only
    {16'h00FF, 8'hA5, 8'h5A},   // R1 lower word only
    {16'h9C63, 8'h3C, 8'hC3}    // R1 scattered
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  // expected events from the field layout of R1
  function automatic logic [7:0] expRise(logic [15:0] cfg, logic [7:0] f, logic [7:0] t);
    logic [7:0] e;
    for (int n = 0; n < 8; n++) e[n] = cfg[2*n] & ~f[n] & t[n];
    return e;
  endfunction
  function automatic logic [7:0] expFall(logic [15:0] cfg, logic [7:0] f, logic [7:0] t);
    logic [7:0] e;
    for (int n = 0; n < 8; n++) e[n] = cfg[2*n+1] & f[n] & ~t[n];
    return e;
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    tick(); tick();
    check("R9 rise in reset", riseEvt, 8'h00);
    check("R9 fall in reset", fallEvt, 8'h00);
    rstN = 1'b1;
    tick();
    regAddr = 1'b0; #1 check("R9 word0 reset", regRdData, 8'h00);
    regAddr = 1'b1; #1 check("R9 word1 reset", regRdData, 8'h00);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [15:0] cfg;
      logic [7:0]  f, t;
      cfg = VEC[v][31:16]; f = VEC[v][15:8]; t = VEC[v][7:0];
      pinIn = f;
      repeat (5) tick();
      writeReg(1'b0, cfg[7:0]);
      writeReg(1'b1, cfg[15:8]);
      regAddr = 1'b0; #1 check("R10 read word0", regRdData, cfg[7:0]);
      regAddr = 1'b1; #1 check("R10 read word1", regRdData, cfg[15:8]);
      pinIn = t;
      tick(); tick();
      check("R6 rise not early", riseEvt, 8'h00);
      check("R6 fall not early", fallEvt, 8'h00);
      tick();
      check("R1 R2 R4 R5 rise", riseEvt, expRise(cfg, f, t));
      check("R1 R3 R4 R5 fall", fallEvt, expFall(cfg, f, t));
      tick();
      check("R6 rise one cycle", riseEvt, 8'h00);
      check("R6 fall one cycle", fallEvt, 8'h00);
    end

    // R7 first sample after reset is silent
    rstN = 1'b0; pinIn = 8'hFF;
    tick(); tick();
    rstN = 1'b1;
    writeReg(1'b0, 8'hFF);
    writeReg(1'b1, 8'hFF);
    for (int c = 0; c < 6; c++) begin
      check("R7 no rise at first sample", riseEvt, 8'h00);
      check("R7 no fall at first sample", fallEvt, 8'h00);
      tick();
    end
    pinIn = 8'h00;
    tick(); tick(); tick();
    check("R7 detection live after arm", fallEvt, 8'hFF);

    // R8 mode changes with steady pins
    pinIn = 8'hFF;
    writeReg(1'b0, 8'h00);
    writeReg(1'b1, 8'h00);
    repeat (5) tick();
    for (int c = 0; c < 4; c++) begin
      writeReg(c[0], (c[1] ? 8'hAA : 8'h55));
      check("R8 no rise from mode write", riseEvt, 8'h00);
      check("R8 no fall from mode write", fallEvt, 8'h00);
    end
    regAddr = 1'b1; #1 check("R8 last write landed", regRdData, 8'hAA);
    tick();
    check("R8 still silent", riseEvt | fallEvt, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule